// File: doc/BRIEF.md
# Command/Response Status and Burst Controller

This block runs the byte-wide register handshake between a host and a command execution engine. The host writes a command into a data port, one byte at a time. The block stores the bytes in an internal buffer. It reads the total command length from the header and keeps the data-expected flag high until that many bytes have arrived. The host then sets the go bit. The block streams the buffered command out to the execution side, one byte per cycle. It then collects the response bytes from the execution side into the same buffer, using the length field in the response header. When the response is complete it raises data-available, and the host drains the response through the data port.

The status register also carries a 16-bit burst count. This tells the host how many bytes it can move without polling: the free space while a command is being written, and the bytes still unread while a response is waiting. Writing the command-ready bit abandons whatever is in progress and returns the block to its empty ready state. Three one-cycle pulses mark the rising edges of status-valid, data-available and command-ready, for use by an interrupt controller.

Top module: `cmd_rsp_ctrl`

## Requirements
- R1: The status byte at offset 0x18 reads bit 7 = status valid, bit 6 = command ready, bit 5 = go (always reads 0), bit 4 = data available, bit 3 = data expected, bits 2..0 = 0. After reset it reads 0xC8.
- R2: The burst count reads low byte at 0x19 and high byte at 0x1A. While command bytes are expected it equals DEPTH minus the bytes written (64 after reset). It is 0 whenever no transfer is possible.
- R3: Header bytes at positions 2..5 form a big-endian length. The length is clamped to the range [10, DEPTH], and the header is always read as unfinished until 6 bytes have arrived. Data expected stays 1 while fewer bytes than that length have been written, and falls to 0 when the last byte is written.
- R4: Data-port writes (offset 0x24) made while data expected is 0 are discarded. They change neither the burst count nor the command that is later streamed.
- R5: A go write made before the command is complete is ignored. A go write after the command is complete starts execution, and status valid then reads 0 until the response is complete.
- R6: After an accepted go, the command bytes appear on the command stream one per cycle, in write order. The first byte appears two cycles after the go write. The final byte is flagged as last.
- R7: The response ready output is high only while response bytes are still expected, by the response's own clamped header length. After the final response byte, status reads valid = 1 and data available = 1.
- R8: Host reads of the data port return the response bytes in order. The burst count shows the unread byte count, and data available falls to 0 after the final byte is read.
- R9: A status write with bit 6 set returns the block to the ready state with an empty buffer, from any state. It wins over a go bit in the same write and over a response byte taken in the same cycle.
- R10: Each of the outputs pulse_valid, pulse_avail and pulse_ready rises for exactly one cycle, one cycle after its flag (status valid, data available, command ready) rises. The flags are taken as 0 during reset.
- R11: Register read data appears on the cycle after the read strobe. Offsets other than 0x18, 0x19, 0x1A and 0x24 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W | Register offset |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid the cycle after host_rd |
| cmd_valid | output | 1 | Command stream byte valid |
| cmd_data | output | 8 | Command stream byte |
| cmd_last | output | 1 | Final command byte |
| rsp_valid | input | 1 | Response byte offered |
| rsp_data | input | 8 | Response byte |
| rsp_ready | output | 1 | Response byte is taken when high with rsp_valid |
| pulse_valid | output | 1 | Rise of status valid |
| pulse_avail | output | 1 | Rise of data available |
| pulse_ready | output | 1 | Rise of command ready |

## Verification
An abort can reach the block in the same cycle as another event that also wants to change the buffer state. Two such collisions are forced. In the first, the command-ready write lands in the very cycle a response byte is handed over. In the second, command-ready and go are set together in one status write. In both cases the abort must win. The status must read 0xC8 and the burst count must read the full 64 afterwards, with no byte streamed and no stale length carried into the next command, which a fresh short command then confirms.

// File: rtl/cr_pkg.sv
package cr_pkg;
  typedef enum logic [2:0] {
    ST_READY, ST_RECV, ST_EXEC, ST_RESP, ST_DONE
  } cr_state_t;

  // status byte bit positions (host visible)
  localparam int B_VALID  = 7;
  localparam int B_READY  = 6;
  localparam int B_GO     = 5;
  localparam int B_AVAIL  = 4;
  localparam int B_EXPECT = 3;

  // flag vector order for the edge pulses
  localparam int N_FLAGS  = 3;
  localparam int FL_VALID = 0;
  localparam int FL_AVAIL = 1;
  localparam int FL_READY = 2;
endpackage

// File: rtl/cr_buf_mem.sv
module cr_buf_mem #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cr_hdr_len.sv
// Collects the big-endian length field from a header and turns it into the
// clamped byte target for the current byte count.
module cr_hdr_len #(
  parameter int DEPTH     = 64,
  parameter int HDR_BYTES = 10,
  parameter int LEN_POS   = 2,
  parameter int LEN_BYTES = 4,
  parameter int CW        = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [CW-1:0] idx,
  input  logic [7:0]    byte_in,
  output logic [CW-1:0] tgt
);
  localparam int LW      = 8 * LEN_BYTES;
  localparam int LEN_END = LEN_POS + LEN_BYTES;

  logic [LW-1:0] len_q;
  logic [CW-1:0] clamped;
  logic          in_field;

  assign in_field = (idx >= CW'(LEN_POS)) && (idx < CW'(LEN_END));

  always_ff @(posedge clk) begin
    if (rst || clr)            len_q <= '0;
    else if (push && in_field) len_q <= {len_q[LW-9:0], byte_in};
  end

  always_comb begin
    if (len_q < LW'(HDR_BYTES))  clamped = CW'(HDR_BYTES);
    else if (len_q > LW'(DEPTH)) clamped = CW'(DEPTH);
    else                         clamped = len_q[CW-1:0];
    tgt = (idx < CW'(LEN_END)) ? CW'(DEPTH) : clamped;
  end
endmodule

// File: rtl/cr_rise_det.sv
module cr_rise_det #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flags,
  output logic [N-1:0] pulses
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic prev_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q    <= 1'b0;
        pulses[i] <= 1'b0;
      end else begin
        prev_q    <= flags[i];
        pulses[i] <= flags[i] & ~prev_q;
      end
    end
  end
endmodule

// File: rtl/cmd_rsp_ctrl.sv
module cmd_rsp_ctrl
  import cr_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DEPTH     = 64,
  parameter int HDR_BYTES = 10,
  parameter int LEN_POS   = 2,
  parameter int LEN_BYTES = 4,
  parameter logic [ADDR_W-1:0] STS_OFS  = 'h18,
  parameter logic [ADDR_W-1:0] FIFO_OFS = 'h24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              cmd_valid,
  output logic [7:0]        cmd_data,
  output logic              cmd_last,
  input  logic              rsp_valid,
  input  logic [7:0]        rsp_data,
  output logic              rsp_ready,
  output logic              pulse_valid,
  output logic              pulse_avail,
  output logic              pulse_ready
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [ADDR_W-1:0] BLO_OFS = STS_OFS + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] BHI_OFS = STS_OFS + ADDR_W'(2);

  cr_state_t     state;
  logic [CW-1:0] wcnt, rptr, tgt;
  logic          is_ready, is_exec, accepting, more, expect_f, sts_valid, avail;
  logic          abort, go, fifo_wr, rsp_take, exec_last, host_pop, push;
  logic [7:0]    push_byte, mem_q, sts_byte, rdata_q;
  logic [15:0]   burst;
  logic          fifo_sel_q;
  logic [N_FLAGS-1:0] flags, pulses;

  // state decode
  assign is_ready  = (state == ST_READY);
  assign is_exec   = (state == ST_EXEC);
  assign accepting = is_ready || (state == ST_RECV);
  assign more      = (wcnt < tgt);
  assign expect_f  = accepting && more;
  assign sts_valid = !is_exec && (state != ST_RESP);
  assign avail     = (state == ST_DONE) && (rptr < wcnt);

  // host and stream events
  assign abort     = host_wr && (host_addr == STS_OFS) && host_wdata[B_READY];
  assign go        = host_wr && (host_addr == STS_OFS) && host_wdata[B_GO]
                     && (state == ST_RECV) && !more;
  assign fifo_wr   = host_wr && (host_addr == FIFO_OFS) && expect_f;
  assign rsp_ready = (state == ST_RESP) && more;
  assign rsp_take  = rsp_valid && rsp_ready;
  assign exec_last = is_exec && ((rptr + CW'(1)) == tgt);
  assign host_pop  = host_rd && (host_addr == FIFO_OFS) && avail;
  assign push      = fifo_wr || rsp_take;
  assign push_byte = fifo_wr ? host_wdata : rsp_data;

  cr_hdr_len #(
    .DEPTH(DEPTH), .HDR_BYTES(HDR_BYTES), .LEN_POS(LEN_POS),
    .LEN_BYTES(LEN_BYTES), .CW(CW)
  ) u_len (
    .clk(clk), .rst(rst), .clr(abort || exec_last), .push(push),
    .idx(wcnt), .byte_in(push_byte), .tgt(tgt)
  );

  cr_buf_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .we(push), .waddr(wcnt[AW-1:0]), .wdata(push_byte),
    .raddr(rptr[AW-1:0]), .rdata(mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      state <= ST_READY;
      wcnt  <= '0;
      rptr  <= '0;
    end else if (go) begin
      state <= ST_EXEC;
      rptr  <= '0;
    end else begin
      case (state)
        ST_READY, ST_RECV: begin
          if (fifo_wr) begin
            wcnt  <= wcnt + CW'(1);
            state <= ST_RECV;
          end
        end
        ST_EXEC: begin
          if (exec_last) begin
            state <= ST_RESP;
            wcnt  <= '0;
            rptr  <= '0;
          end else begin
            rptr <= rptr + CW'(1);
          end
        end
        ST_RESP: begin
          if (rsp_take) wcnt <= wcnt + CW'(1);
          else if (!more) begin
            state <= ST_DONE;
            rptr  <= '0;
          end
        end
        ST_DONE: if (host_pop) rptr <= rptr + CW'(1);
        default: state <= ST_READY;
      endcase
    end
  end

  // burst count and status byte
  always_comb begin
    if (expect_f)              burst = 16'(CW'(DEPTH) - wcnt);
    else if (state == ST_DONE) burst = 16'(wcnt - rptr);
    else                       burst = '0;
    sts_byte           = '0;
    sts_byte[B_VALID]  = sts_valid;
    sts_byte[B_READY]  = is_ready;
    sts_byte[B_AVAIL]  = avail;
    sts_byte[B_EXPECT] = expect_f;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q    <= '0;
      fifo_sel_q <= 1'b0;
      cmd_valid  <= 1'b0;
      cmd_last   <= 1'b0;
    end else begin
      if (host_rd) begin
        fifo_sel_q <= (host_addr == FIFO_OFS);
        case (host_addr)
          STS_OFS: rdata_q <= sts_byte;
          BLO_OFS: rdata_q <= burst[7:0];
          BHI_OFS: rdata_q <= burst[15:8];
          default: rdata_q <= '0;
        endcase
      end
      cmd_valid <= is_exec;
      cmd_last  <= exec_last;
    end
  end

  assign host_rdata = fifo_sel_q ? mem_q : rdata_q;
  assign cmd_data   = mem_q;

  assign flags[FL_VALID] = sts_valid;
  assign flags[FL_AVAIL] = avail;
  assign flags[FL_READY] = is_ready;

  cr_rise_det #(.N(N_FLAGS)) u_rise (
    .clk(clk), .rst(rst), .flags(flags), .pulses(pulses)
  );

  assign pulse_valid = pulses[FL_VALID];
  assign pulse_avail = pulses[FL_AVAIL];
  assign pulse_ready = pulses[FL_READY];
endmodule

// File: rtl/cmd_rsp_ctrl_chk.sv
module cmd_rsp_ctrl_chk #(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 64,
  parameter int CW     = 7,
  parameter logic [ADDR_W-1:0] STS_OFS = 'h18
) (
  input logic              clk,
  input logic              rst,
  input logic              host_wr,
  input logic [ADDR_W-1:0] host_addr,
  input logic [7:0]        host_wdata,
  input logic              cmd_valid,
  input logic              cmd_last,
  input logic              rsp_ready,
  input logic              sts_valid,
  input logic              avail,
  input logic              pulse_valid,
  input logic              pulse_avail,
  input logic              is_ready,
  input logic              is_exec,
  input logic [CW-1:0]     wcnt,
  input logic [15:0]       burst
);
  // R9: a command-ready write always lands in the empty ready state
  a_r9_abort_to_ready: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == STS_OFS && host_wdata[6]) |=> (is_ready && wcnt == '0));

  // R6: the stream closes after the byte flagged last
  a_r6_last_closes: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_last) |=> !cmd_valid);

  // R10: rising flags are followed by their pulses
  a_r10_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    $rose(sts_valid) |=> pulse_valid);
  a_r10_avail_pulse: assert property (@(posedge clk) disable iff (rst)
    $rose(avail) |=> pulse_avail);

  // R3: the byte count never exceeds the buffer
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    wcnt <= CW'(DEPTH));

  // R7: response intake happens only while status is not valid
  a_r7_intake_hides_valid: assert property (@(posedge clk) disable iff (rst)
    rsp_ready |-> !sts_valid);

  // R5: no burst is offered while the command executes
  a_r5_exec_no_burst: assert property (@(posedge clk) disable iff (rst)
    is_exec |-> burst == 16'd0);
endmodule

bind cmd_rsp_ctrl cmd_rsp_ctrl_chk #(
  .ADDR_W(ADDR_W), .DEPTH(DEPTH), .CW(CW), .STS_OFS(STS_OFS)
) u_chk (
  .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
  .host_wdata(host_wdata), .cmd_valid(cmd_valid), .cmd_last(cmd_last),
  .rsp_ready(rsp_ready), .sts_valid(sts_valid), .avail(avail),
  .pulse_valid(pulse_valid), .pulse_avail(pulse_avail),
  .is_ready(is_ready), .is_exec(is_exec), .wcnt(wcnt), .burst(burst)
);

// File: tb/tb_cmd_rsp_ctrl.sv
module tb_cmd_rsp_ctrl;
  localparam logic [11:0] A_STS = 12'h18, A_BLO = 12'h19, A_BHI = 12'h1A,
                          A_FIFO = 12'h24, A_NONE = 12'h30;

  logic clk = 0, rst = 1;
  logic [11:0] host_addr = '0;
  logic host_wr = 0, host_rd = 0, rsp_valid = 0;
  logic [7:0] host_wdata = '0, rsp_data = '0;
  logic [7:0] host_rdata, cmd_data;
  logic cmd_valid, cmd_last, rsp_ready, pulse_valid, pulse_avail, pulse_ready;

  always #2 clk = ~clk;

  cmd_rsp_ctrl dut (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_last(cmd_last),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ready(rsp_ready),
    .pulse_valid(pulse_valid), .pulse_avail(pulse_avail), .pulse_ready(pulse_ready)
  );

  int total = 0, bad = 0, cycles = 0;
  bit fin = 0;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int ms, mw, mr;            // 0 ready, 1 receiving, 2 executing, 3 collecting, 4 draining
  logic [31:0] mlen;
  logic [7:0]  mbuf [64];
  bit pv_v, pv_a, pv_r, e_pv, e_pa, e_pr, e_cv, e_cl, chk_rd;
  logic [7:0] e_cd, e_rd;
  string rd_tag = "", pend_tag = "";

  function automatic int mtgt(int w);
    if (w < 6) return 64;
    if (mlen < 10) return 10;
    if (mlen > 64) return 64;
    return int'(mlen);
  endfunction

  function automatic void mput(logic [7:0] b);
    mbuf[mw] = b;
    if (mw >= 2 && mw < 6) mlen = {mlen[23:0], b};
    mw++;
  endfunction

  always @(negedge clk) begin
    if (!rst && !fin) begin
      chk("R7 rsp_ready", 16'(rsp_ready), 16'(ms == 3 && mw < mtgt(mw)));
      chk("R6 cmd_valid", 16'(cmd_valid), 16'(e_cv));
      if (e_cv) begin
        chk("R6 cmd_data", 16'(cmd_data), 16'(e_cd));
        chk("R6 cmd_last", 16'(cmd_last), 16'(e_cl));
      end
      chk("R10 pulse_valid", 16'(pulse_valid), 16'(e_pv));
      chk("R10 pulse_avail", 16'(pulse_avail), 16'(e_pa));
      chk("R10 pulse_ready", 16'(pulse_ready), 16'(e_pr));
      if (chk_rd) chk(rd_tag, 16'(host_rdata), 16'(e_rd));
    end
    if (rst) begin
      ms = 0; mw = 0; mr = 0; mlen = 0;
      pv_v = 0; pv_a = 0; pv_r = 0; e_pv = 0; e_pa = 0; e_pr = 0;
      e_cv = 0; e_cl = 0; chk_rd = 0;
    end else begin
      bit cv, ca, cr, acc, more;
      int burst;
      cv = (ms != 2 && ms != 3); ca = (ms == 4 && mr < mw); cr = (ms == 0);
      acc = (ms <= 1); more = (mw < mtgt(mw));
      burst = (acc && more) ? 64 - mw : (ms == 4) ? mw - mr : 0;
      e_pv = cv && !pv_v; e_pa = ca && !pv_a; e_pr = cr && !pv_r;
      pv_v = cv; pv_a = ca; pv_r = cr;
      e_cv = (ms == 2); e_cd = mbuf[mr % 64]; e_cl = (mr + 1 == mtgt(mw));
      chk_rd = host_rd; rd_tag = pend_tag;
      case (host_addr)
        A_STS:  e_rd = {cv, cr, 1'b0, ca, acc && more, 3'b000};
        A_BLO:  e_rd = 8'(burst);
        A_BHI:  e_rd = 8'(burst >> 8);
        A_FIFO: begin e_rd = mbuf[mr % 64]; chk_rd = host_rd && ca; end
        default: e_rd = 8'h00;
      endcase
      if (host_wr && host_addr == A_STS && host_wdata[6]) begin
        ms = 0; mw = 0; mr = 0; mlen = 0;
      end else if (host_wr && host_addr == A_STS && host_wdata[5] && ms == 1 && !more) begin
        ms = 2; mr = 0;
      end else if (host_wr && host_addr == A_FIFO && acc && more) begin
        mput(host_wdata); ms = 1;
      end else if (ms == 2) begin
        if (mr + 1 == mtgt(mw)) begin ms = 3; mw = 0; mr = 0; mlen = 0; end
        else mr++;
      end else if (ms == 3) begin
        if (more) begin if (rsp_valid) mput(rsp_data); end
        else begin ms = 4; mr = 0; end
      end else if (ms == 4 && host_rd && host_addr == A_FIFO && mr < mw) begin
        mr++;
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [11:0] a, logic [7:0] d);
    host_wr = 1; host_addr = a; host_wdata = d; cyc(); host_wr = 0;
  endtask

  task automatic rd(logic [11:0] a, string tag);
    pend_tag = tag; host_rd = 1; host_addr = a; cyc(); host_rd = 0; cyc();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  function automatic logic [7:0] pbyte(int i, logic [31:0] len, logic [7:0] salt);
    if (i == 0) return 8'h80;
    if (i == 1) return 8'h01;
    if (i >= 2 && i <= 5) return len[8*(5-i) +: 8];
    return 8'(i * 7) ^ salt;
  endfunction

  task automatic send_cmd(int first, int n, logic [31:0] len);
    for (int i = first; i < first + n; i++) wr(A_FIFO, pbyte(i, len, 8'h3C));
  endtask

  task automatic send_rsp(int n, logic [31:0] len);
    for (int i = 0; i < n; i++) begin
      while (!rsp_ready) cyc();
      rsp_valid = 1; rsp_data = pbyte(i, len, 8'hA5); cyc(); rsp_valid = 0;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !fin) begin
      fin = 1; bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(4); rst = 0;
    // reset state and decode
    rd(A_STS, "R1 reset status"); rd(A_BLO, "R2 burst lo"); rd(A_BHI, "R2 burst hi");
    rd(A_NONE, "R11 unmapped"); rd(A_FIFO, "R11 fifo idle");
    // normal 12-byte command
    send_cmd(0, 3, 12);
    rd(A_BLO, "R2 free space"); rd(A_STS, "R3 expect mid");
    wr(A_STS, 8'h20); rd(A_STS, "R5 early go ignored");
    send_cmd(3, 9, 12);
    rd(A_STS, "R3 expect done");
    wr(A_FIFO, 8'hEE); rd(A_BLO, "R4 burst after discard"); rd(A_STS, "R4 status");
    wr(A_STS, 8'h20); rd(A_STS, "R5 executing");
    idle(20);
    send_rsp(14, 14);
    rsp_valid = 1; rsp_data = 8'h77; idle(3); rsp_valid = 0;
    rd(A_STS, "R7 response ready"); rd(A_BLO, "R8 burst remaining");
    for (int i = 0; i < 14; i++) rd(A_FIFO, "R8 response byte");
    rd(A_STS, "R8 drained"); rd(A_BLO, "R8 burst empty");
    // short length clamps to header size
    wr(A_STS, 8'h40); rd(A_STS, "R9 back to ready");
    send_cmd(0, 10, 5); rd(A_STS, "R3 clamp low");
    wr(A_STS, 8'h20); idle(20);
    send_rsp(10, 3);
    for (int i = 0; i < 10; i++) rd(A_FIFO, "R8 short response");
    rd(A_STS, "R8 short drained");
    // long length clamps to buffer depth, abort colliding with a response byte
    wr(A_STS, 8'h40);
    send_cmd(0, 64, 32'h100); rd(A_STS, "R3 clamp high"); rd(A_BLO, "R2 full no burst");
    wr(A_STS, 8'h20);
    send_rsp(3, 40);
    while (!rsp_ready) cyc();
    rsp_valid = 1; rsp_data = 8'h55;
    host_wr = 1; host_addr = A_STS; host_wdata = 8'h40; cyc();
    host_wr = 0; rsp_valid = 0;
    rd(A_STS, "R9 abort vs byte"); rd(A_BLO, "R9 empty buffer");
    // abort and go in one write
    send_cmd(0, 12, 12);
    wr(A_STS, 8'h60); rd(A_STS, "R9 abort beats go"); rd(A_BLO, "R9 burst after");
    idle(4);
    // abort part-way through a command, then a fresh command
    send_cmd(0, 4, 30);
    wr(A_STS, 8'h40); rd(A_BLO, "R9 mid command");
    send_cmd(0, 10, 10); rd(A_STS, "R3 fresh parse");
    idle(4);
    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule